// File: doc/BRIEF.md
# Host-Locked Two-Phase Coprocessor Clock Generator

This block makes the clock for a coprocessor that shares memory with a slower host processor. It runs from a fast clock of about 7 MHz and watches the host's phase-1 level. Every host cycle produces two coprocessor clock periods. The first is a short period, made by halving the fast clock at the start of phase 1. The second is a long period that covers the rest of phase 1 and all of phase 0. Because of this, the coprocessor's long period, and any memory access placed in it, always lines up with the host's phase 0. Two host cycles of coprocessor time fit in 14 fast ticks, which gives an average coprocessor rate of about 2.04 MHz.

When the coprocessor must move its next memory access to the following host cycle, it raises a sync request. The block samples this request once per host cycle, on the tick where phase 1 begins. A set request makes that host cycle hold a second short period in place of the long one, so the next long period starts one host cycle later.

Besides the clock, the block drives a level that is high while the long period is active, and a one-tick pulse at the start of the long period. An arbiter uses these to place coprocessor bus accesses in phase 0.

Top module: `clkstretch_gen`

## Requirements
- R1: From reset until the first rising edge of `host_ph1`, `cop_clk`, `cop_long` and `cop_long_start` are all 0.
- R2: Tick 0 of a host cycle is the first fast-clock edge that sees `host_ph1` high after it was low. `cop_clk` is 1 for tick 0 and 0 for tick 1. This is the short period.
- R3: In a host cycle without insertion, `cop_clk` is 1 on ticks 2 and 3 and 0 from tick 4 to the end of the host cycle. `cop_long` is 1 from tick 2 to the end of the host cycle and 0 on ticks 0 and 1.
- R4: `cop_long_start` is 1 only on tick 2 of a host cycle without insertion. It lasts exactly one tick, and `cop_clk` rises to 1 on that same tick.
- R5: `sync_req` is used only on tick 0. Its value on every other tick has no effect on any output.
- R6: If `sync_req` is 1 on tick 0, that host cycle gives `cop_clk` = 1 on ticks 0 and 2 and 0 on all other ticks. `cop_long` and `cop_long_start` stay 0 for the whole host cycle.
- R7: If a host cycle runs past tick 6, the outputs keep their tick-6 values until the next `host_ph1` rising edge.
- R8: A `host_ph1` rising edge that comes before tick 6 restarts the pattern at tick 0.
- R9: Keeping `host_ph1` high without a new rising edge never restarts the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock, about 7 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ph1 | input | 1 | Host phase level, 1 during phase 1, synchronous to clk_fast |
| sync_req | input | 1 | Request to insert an extra short period in this host cycle |
| cop_clk | output | 1 | Coprocessor clock |
| cop_long | output | 1 | 1 while the long (stretched) period is active |
| cop_long_start | output | 1 | One-tick pulse on the first tick of the long period |

## Verification
The tests use nominal 7-tick host cycles, with the sync request both set and clear, to tell the normal short/long waveform apart from the insertion waveform. Host cycles that are too short or too long show whether the tick count restarts on every phase-1 edge and holds once it reaches the last tick. A phase-1 level held high for many ticks shows that a steady high level does not restart the pattern. Random toggling of the sync request away from tick 0 shows that the request is sampled at only one point in each host cycle. Random host cycle lengths and phase splits are then compared tick by tick against a waveform function computed from the tick index.

// File: rtl/clkstretch_pkg.sv
package clkstretch_pkg;

  // One registered output sample of the clock pattern
  typedef struct packed {
    logic level;       // coprocessor clock level
    logic long_cyc;    // stretched period active
    logic long_start;  // first tick of stretched period
  } cs_pat_t;

  localparam cs_pat_t CS_PAT_IDLE = '{level: 1'b0, long_cyc: 1'b0, long_start: 1'b0};

endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_fast,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain_q[STAGES-1];

endmodule

// File: rtl/cs_phase_track.sv
module cs_phase_track #(
  parameter int HOST_TICKS = 7,
  parameter int TW         = 3
) (
  input  logic          clk_fast,
  input  logic          rst_ns,
  input  logic          host_ph1,
  input  logic          sync_req,
  output logic [TW-1:0] tick_nxt,
  output logic [TW-1:0] tick_q,
  output logic          ins_nxt,
  output logic          ins_q,
  output logic          locked_nxt,
  output logic          locked_q
);

  localparam logic [TW-1:0] LAST_TICK = TW'(HOST_TICKS - 1);

  logic ph1_q;
  logic ph1_rise;
  logic tick_en;

  // host_ph1 level that was seen at the previous edge
  always_ff @(posedge clk_fast or negedge rst_ns) begin
    if (!rst_ns) ph1_q <= 1'b0;
    else         ph1_q <= host_ph1;
  end

  assign ph1_rise = host_ph1 & ~ph1_q;

  // Next state: restart on a phase-1 edge, otherwise count up and stop at the last tick
  always_comb begin
    tick_en    = ph1_rise | (tick_q != LAST_TICK);
    tick_nxt   = tick_q;
    if (ph1_rise)               tick_nxt = '0;
    else if (tick_q != LAST_TICK) tick_nxt = tick_q + 1'b1;
    ins_nxt    = ph1_rise ? sync_req : ins_q;
    locked_nxt = locked_q | ph1_rise;
  end

  // Register process, with clock enables written out
  always_ff @(posedge clk_fast or negedge rst_ns) begin
    if (!rst_ns) begin
      tick_q   <= LAST_TICK;
      ins_q    <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (tick_en)  tick_q   <= tick_nxt;
      if (ph1_rise) ins_q    <= ins_nxt;
      if (ph1_rise) locked_q <= locked_nxt;
    end
  end

endmodule

// File: rtl/cs_pattern.sv
module cs_pattern
  import clkstretch_pkg::*;
#(
  parameter int SHORT_HALF = 1,
  parameter int PH1_TICKS  = 4,
  parameter int TW         = 3
) (
  input  logic [TW-1:0] tick,
  input  logic          ins,
  input  logic          locked,
  output cs_pat_t       pat
);

  localparam logic [TW-1:0] T_HALF  = TW'(SHORT_HALF);
  localparam logic [TW-1:0] T_LONG  = TW'(2 * SHORT_HALF);
  localparam logic [TW-1:0] T_XHIGH = TW'(3 * SHORT_HALF);
  localparam logic [TW-1:0] T_PH0   = TW'(PH1_TICKS);

  logic in_short;

  always_comb begin
    in_short = (tick < T_HALF);
    pat      = CS_PAT_IDLE;
    if (locked) begin
      if (ins) begin
        // extra short period replaces the stretched one
        pat.level = in_short | ((tick >= T_LONG) && (tick < T_XHIGH));
      end else begin
        pat.level      = in_short | ((tick >= T_LONG) && (tick < T_PH0));
        pat.long_cyc   = (tick >= T_LONG);
        pat.long_start = (tick == T_LONG);
      end
    end
  end

endmodule

// File: rtl/cs_out_reg.sv
module cs_out_reg
  import clkstretch_pkg::*;
(
  input  logic    clk_fast,
  input  logic    rst_ns,
  input  cs_pat_t pat_d,
  output cs_pat_t pat_q
);

  always_ff @(posedge clk_fast or negedge rst_ns) begin
    if (!rst_ns) pat_q <= CS_PAT_IDLE;
    else         pat_q <= pat_d;
  end

endmodule

// File: rtl/clkstretch_gen.sv
module clkstretch_gen
  import clkstretch_pkg::*;
#(
  parameter int HOST_TICKS = 7,
  parameter int PH1_TICKS  = 4,
  parameter int SHORT_HALF = 1
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic host_ph1,
  input  logic sync_req,
  output logic cop_clk,
  output logic cop_long,
  output logic cop_long_start
);

  localparam int TW = $clog2(HOST_TICKS);

  logic          rst_ns;
  logic [TW-1:0] tick_nxt;
  logic [TW-1:0] tick_q;
  logic          ins_nxt;
  logic          ins_q;
  logic          locked_nxt;
  logic          locked_q;
  cs_pat_t       pat_d;
  cs_pat_t       pat_q;

  cs_rst_sync #(.STAGES(2)) u_rst (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .rst_ns   (rst_ns)
  );

  cs_phase_track #(.HOST_TICKS(HOST_TICKS), .TW(TW)) u_track (
    .clk_fast   (clk_fast),
    .rst_ns     (rst_ns),
    .host_ph1   (host_ph1),
    .sync_req   (sync_req),
    .tick_nxt   (tick_nxt),
    .tick_q     (tick_q),
    .ins_nxt    (ins_nxt),
    .ins_q      (ins_q),
    .locked_nxt (locked_nxt),
    .locked_q   (locked_q)
  );

  // The pattern is decoded from next-state values, so the output register lines up with the tick register
  cs_pattern #(.SHORT_HALF(SHORT_HALF), .PH1_TICKS(PH1_TICKS), .TW(TW)) u_pat (
    .tick   (tick_nxt),
    .ins    (ins_nxt),
    .locked (locked_nxt),
    .pat    (pat_d)
  );

  cs_out_reg u_out (
    .clk_fast (clk_fast),
    .rst_ns   (rst_ns),
    .pat_d    (pat_d),
    .pat_q    (pat_q)
  );

  assign cop_clk        = pat_q.level;
  assign cop_long       = pat_q.long_cyc;
  assign cop_long_start = pat_q.long_start;

endmodule

// File: rtl/clkstretch_chk.sv
module clkstretch_chk #(
  parameter int TW = 3
) (
  input logic          clk_fast,
  input logic          rst_ns,
  input logic [TW-1:0] tick_q,
  input logic          ins_q,
  input logic          locked_q,
  input logic          cop_clk,
  input logic          cop_long,
  input logic          cop_long_start
);

  assert_idle_unlocked_R1: assert property (@(posedge clk_fast) disable iff (!rst_ns)
    !locked_q |-> (!cop_clk && !cop_long && !cop_long_start));

  assert_short_high_R2: assert property (@(posedge clk_fast) disable iff (!rst_ns)
    (locked_q && tick_q == '0) |-> cop_clk);

  assert_long_rise_marked_R3: assert property (@(posedge clk_fast) disable iff (!rst_ns)
    $rose(cop_long) |-> cop_long_start);

  assert_start_with_edge_R4: assert property (@(posedge clk_fast) disable iff (!rst_ns)
    cop_long_start |-> (cop_long && cop_clk && !$past(cop_clk)));

  assert_start_single_R4: assert property (@(posedge clk_fast) disable iff (!rst_ns)
    cop_long_start |=> !cop_long_start);

  assert_insert_no_long_R6: assert property (@(posedge clk_fast) disable iff (!rst_ns)
    ins_q |-> (!cop_long && !cop_long_start));

endmodule

bind clkstretch_gen clkstretch_chk #(.TW(TW)) u_chk (
  .clk_fast       (clk_fast),
  .rst_ns         (rst_ns),
  .tick_q         (tick_q),
  .ins_q          (ins_q),
  .locked_q       (locked_q),
  .cop_clk        (cop_clk),
  .cop_long       (cop_long),
  .cop_long_start (cop_long_start)
);

// File: tb/tb_clkstretch_gen.sv
`timescale 1ns/1ps
module tb_clkstretch_gen;

  logic clk_fast = 1'b0;
  logic rst_n;
  logic host_ph1;
  logic sync_req;
  logic cop_clk, cop_long, cop_long_start;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk_fast = ~clk_fast;

  clkstretch_gen dut (
    .clk_fast       (clk_fast),
    .rst_n          (rst_n),
    .host_ph1       (host_ph1),
    .sync_req       (sync_req),
    .cop_clk        (cop_clk),
    .cop_long       (cop_long),
    .cop_long_start (cop_long_start)
  );

  // Expected waveform, computed from the tick index and the insertion flag
  function automatic bit e_clk(int t, bit s);
    int c = (t > 6) ? 6 : t;
    if (s) return (c == 0) || (c == 2);
    return (c == 0) || (c == 2) || (c == 3);
  endfunction

  function automatic bit e_long(int t, bit s);
    return !s && (t >= 2);
  endfunction

  function automatic bit e_start(int t, bit s);
    return !s && (t == 2);
  endfunction

  task automatic check(string req, string what, bit act, bit exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One host cycle: len ticks, phase 1 on the first ph1len ticks, sync value s on tick 0
  task automatic host_cyc(int len, int ph1len, bit s, bit noise, string tag);
    for (int t = 0; t < len; t++) begin
      @(negedge clk_fast);
      host_ph1 = (t < ph1len);
      if (t == 0)     sync_req = s;
      else if (noise) sync_req = ($urandom_range(1, 0) == 1);
      else            sync_req = 1'b0;
      @(posedge clk_fast);
      #1;
      begin
        string rq;
        if (tag != "")   rq = tag;
        else if (t < 2)  rq = "R2";
        else if (s)      rq = "R6";
        else if (t > 6)  rq = "R7";
        else             rq = "R3";
        check(rq, "cop_clk", cop_clk, e_clk(t, s));
        check(rq, "cop_long", cop_long, e_long(t, s));
        check((tag != "") ? tag : "R4", "cop_long_start", cop_long_start, e_start(t, s));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n    = 1'b0;
    host_ph1 = 1'b0;
    sync_req = 1'b0;
    repeat (3) @(negedge clk_fast);
    rst_n = 1'b1;
    // R1: idle before any phase-1 edge, even with sync toggling
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_fast);
      sync_req = i[0];
      @(posedge clk_fast);
      #1;
      check("R1", "cop_clk", cop_clk, 1'b0);
      check("R1", "cop_long", cop_long, 1'b0);
      check("R1", "cop_long_start", cop_long_start, 1'b0);
    end
    // nominal cycles
    host_cyc(7, 4, 1'b0, 1'b0, "");
    host_cyc(7, 4, 1'b0, 1'b0, "");
    // R6: insertion, then back to normal
    host_cyc(7, 4, 1'b1, 1'b0, "R6");
    host_cyc(7, 4, 1'b0, 1'b0, "");
    host_cyc(7, 4, 1'b1, 1'b0, "R6");
    host_cyc(7, 4, 1'b1, 1'b0, "R6");
    // R5: sync noise away from tick 0
    host_cyc(7, 4, 1'b0, 1'b1, "R5");
    host_cyc(7, 4, 1'b1, 1'b1, "R5");
    // R7: long host cycle
    host_cyc(10, 4, 1'b0, 1'b0, "R7");
    // R8: early restart
    host_cyc(4, 2, 1'b0, 1'b0, "R8");
    host_cyc(5, 3, 1'b1, 1'b0, "R8");
    host_cyc(3, 1, 1'b0, 1'b0, "R8");
    // R9: phase 1 held high well past a host cycle
    host_cyc(14, 13, 1'b0, 1'b0, "R9");
    host_cyc(7, 4, 1'b0, 1'b0, "");
    // random host cycles
    for (int k = 0; k < 60; k++) begin
      int len = $urandom_range(10, 3);
      int p1  = $urandom_range(len - 1, 1);
      bit s   = ($urandom_range(3, 0) == 0);
      host_cyc(len, p1, s, 1'b1, "");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule